// File: doc/BRIEF.md
# Master Timer Trigger Output Selector

This block generates the trigger line that a master timer sends to its slave timers. A 3-bit select field picks one of six internal timer events or levels. The chosen source is registered before it reaches the output. The six sources are:

- the software update-generate strobe
- the counter-enable signal, which can be gated by an external trigger
- the update event
- a pulse on every channel-1 capture/compare flag-set condition
- the channel-1 compare reference
- the channel-2 compare reference

The block also contains the channel-1 input selector. It feeds the first timer input from either the channel-1 pin alone or the XOR of the channel-1 and channel-2 pins. This lets a single capture channel see edges from both pins, for example from a Hall sensor.

Top module: `trig_out_sel`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it, `trig_out` is 0.
- R2: With `mode_sel` = 0, `trig_out` follows the software update-generate strobe `sw_upd`.
- R3: With `mode_sel` = 1 and `gate_mode` = 1, `trig_out` is `cnt_en_bit` AND `gate_trig`.
- R4: With `mode_sel` = 1 and `gate_mode` = 0, `trig_out` equals `cnt_en_bit` alone, and `gate_trig` has no effect.
- R5: With `mode_sel` = 2, `trig_out` follows the update event `upd_evt`.
- R6: With `mode_sel` = 3, `trig_out` is high for one cycle for each cycle in which `cc1_set` is high. Back-to-back strobes give back-to-back high cycles, with no edge detection and no suppression.
- R7: With `mode_sel` = 4, `trig_out` follows `oc1_ref`.
- R8: With `mode_sel` = 5, `trig_out` follows `oc2_ref`.
- R9: With `mode_sel` = 6 or 7, `trig_out` is 0 whatever the other inputs are.
- R10: `trig_out` has exactly one clock cycle of latency. It shows the selected source as sampled at the previous rising edge of `clk`.
- R11: `tin1` is `ch1_pin` when `xor_sel` = 0, and `ch1_pin` XOR `ch2_pin` when `xor_sel` = 1. It is combinational, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 3 | Trigger source select code |
| sw_upd | input | 1 | Software update-generate strobe |
| cnt_en_bit | input | 1 | Counter enable control bit |
| gate_trig | input | 1 | Trigger input used for gating |
| gate_mode | input | 1 | 1 = gated mode active |
| upd_evt | input | 1 | Update event |
| cc1_set | input | 1 | Channel-1 flag-set strobe |
| oc1_ref | input | 1 | Channel-1 compare reference |
| oc2_ref | input | 1 | Channel-2 compare reference |
| ch1_pin | input | 1 | Channel-1 pin |
| ch2_pin | input | 1 | Channel-2 pin |
| xor_sel | input | 1 | 1 = XOR of both pins drives `tin1` |
| trig_out | output | 1 | Registered trigger for slave timers |
| tin1 | output | 1 | First timer input |

## Verification
The bench goes after the gating of the enable source in both polarities of `gate_mode`. A design that always applied the gate, or never applied it, would give the wrong level on one of those patterns. It drives `cc1_set` for two consecutive cycles to catch an edge detector that merges the two pulses into one. It drives the reserved codes with every source high, so a decoder that falls through to a real source shows up as a high output. It also checks the output in the cycle right after a source change, which exposes both a combinational bypass and an extra pipeline stage.

// File: rtl/trig_out_sel.sv
module trig_out_sel #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] mode_sel,
  input  logic             sw_upd,
  input  logic             cnt_en_bit,
  input  logic             gate_trig,
  input  logic             gate_mode,
  input  logic             upd_evt,
  input  logic             cc1_set,
  input  logic             oc1_ref,
  input  logic             oc2_ref,
  input  logic             ch1_pin,
  input  logic             ch2_pin,
  input  logic             xor_sel,
  output logic             trig_out,
  output logic             tin1
);

  localparam logic [SEL_W-1:0] M_SWUPD = SEL_W'(0);
  localparam logic [SEL_W-1:0] M_ENA   = SEL_W'(1);
  localparam logic [SEL_W-1:0] M_UPD   = SEL_W'(2);
  localparam logic [SEL_W-1:0] M_PULSE = SEL_W'(3);
  localparam logic [SEL_W-1:0] M_OC1   = SEL_W'(4);
  localparam logic [SEL_W-1:0] M_OC2   = SEL_W'(5);

  logic cnt_en;
  logic trig_nxt;

  assign cnt_en = cnt_en_bit & (gate_trig | ~gate_mode);
  assign tin1   = ch1_pin ^ (xor_sel & ch2_pin);

  always_comb begin
    unique case (mode_sel)
      M_SWUPD: trig_nxt = sw_upd;
      M_ENA:   trig_nxt = cnt_en;
      M_UPD:   trig_nxt = upd_evt;
      M_PULSE: trig_nxt = cc1_set;
      M_OC1:   trig_nxt = oc1_ref;
      M_OC2:   trig_nxt = oc2_ref;
      default: trig_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= trig_nxt;
  end

  // one cycle out of reset: $past values are then real samples
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !trig_out || rst_n);

  assert_swupd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_SWUPD |-> trig_out == $past(sw_upd));

  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_ENA && $past(gate_mode) |->
      trig_out == ($past(cnt_en_bit) && $past(gate_trig)));

  assert_ungated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_ENA && !$past(gate_mode) |->
      trig_out == $past(cnt_en_bit));

  assert_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_UPD |-> trig_out == $past(upd_evt));

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_PULSE |-> trig_out == $past(cc1_set));

  assert_oc1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_OC1 |-> trig_out == $past(oc1_ref));

  assert_oc2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) == M_OC2 |-> trig_out == $past(oc2_ref));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_sel) > M_OC2 |-> !trig_out);

endmodule

// File: tb/trig_out_sel_tb.sv
`timescale 1ns/1ps
module trig_out_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic sw_upd = 0, cnt_en_bit = 0, gate_trig = 0, gate_mode = 0, upd_evt = 0;
  logic cc1_set = 0, oc1_ref = 0, oc2_ref = 0, ch1_pin = 0, ch2_pin = 0, xor_sel = 0;
  logic trig_out, tin1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_out_sel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_upd(sw_upd),
    .cnt_en_bit(cnt_en_bit), .gate_trig(gate_trig), .gate_mode(gate_mode),
    .upd_evt(upd_evt), .cc1_set(cc1_set), .oc1_ref(oc1_ref), .oc2_ref(oc2_ref),
    .ch1_pin(ch1_pin), .ch2_pin(ch2_pin), .xor_sel(xor_sel),
    .trig_out(trig_out), .tin1(tin1)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_srcs();
    sw_upd = 0; cnt_en_bit = 0; gate_trig = 0; gate_mode = 0; upd_evt = 0;
    cc1_set = 0; oc1_ref = 0; oc2_ref = 0;
  endtask

  // drive at a falling edge, check at the next falling edge (one rising edge between)
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", trig_out, 1'b0);
    mode_sel = 3'd2; upd_evt = 1;
    step();
    chk("R1", trig_out, 1'b0);
    clear_srcs();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_swupd();
    mode_sel = 3'd0; clear_srcs(); sw_upd = 1; step();
    chk("R2", trig_out, 1'b1);
    sw_upd = 0; step();
    chk("R2", trig_out, 1'b0);
  endtask

  task automatic t_gated();
    mode_sel = 3'd1; clear_srcs(); gate_mode = 1; cnt_en_bit = 1; gate_trig = 0; step();
    chk("R3", trig_out, 1'b0);
    gate_trig = 1; step();
    chk("R3", trig_out, 1'b1);
    cnt_en_bit = 0; step();
    chk("R3", trig_out, 1'b0);
  endtask

  task automatic t_ungated();
    mode_sel = 3'd1; clear_srcs(); gate_mode = 0; cnt_en_bit = 1; gate_trig = 0; step();
    chk("R4", trig_out, 1'b1);
    cnt_en_bit = 0; gate_trig = 1; step();
    chk("R4", trig_out, 1'b0);
  endtask

  task automatic t_update();
    mode_sel = 3'd2; clear_srcs(); upd_evt = 1; step();
    chk("R5", trig_out, 1'b1);
    upd_evt = 0; sw_upd = 1; step();
    chk("R5", trig_out, 1'b0);
  endtask

  task automatic t_pulse();
    mode_sel = 3'd3; clear_srcs(); cc1_set = 1; step();
    chk("R6", trig_out, 1'b1);
    step();
    chk("R6", trig_out, 1'b1);
    cc1_set = 0; step();
    chk("R6", trig_out, 1'b0);
  endtask

  task automatic t_refs();
    mode_sel = 3'd4; clear_srcs(); oc1_ref = 1; step();
    chk("R7", trig_out, 1'b1);
    oc1_ref = 0; oc2_ref = 1; step();
    chk("R7", trig_out, 1'b0);
    mode_sel = 3'd5; step();
    chk("R8", trig_out, 1'b1);
    oc2_ref = 0; oc1_ref = 1; step();
    chk("R8", trig_out, 1'b0);
  endtask

  task automatic t_reserved();
    for (int m = 6; m < 8; m++) begin
      mode_sel = 3'(m);
      sw_upd = 1; cnt_en_bit = 1; gate_trig = 1; upd_evt = 1;
      cc1_set = 1; oc1_ref = 1; oc2_ref = 1;
      step();
      chk("R9", trig_out, 1'b0);
    end
  endtask

  task automatic t_latency();
    mode_sel = 3'd2; clear_srcs(); step();
    upd_evt = 1; #1;
    chk("R10", trig_out, 1'b0);
    @(posedge clk); #1;
    chk("R10", trig_out, 1'b1);
    upd_evt = 0;
    @(posedge clk); #1;
    chk("R10", trig_out, 1'b0);
    step();
  endtask

  task automatic t_tin1();
    for (int v = 0; v < 8; v++) begin
      xor_sel = v[2]; ch1_pin = v[1]; ch2_pin = v[0]; #1;
      chk("R11", tin1, v[2] ? (v[1] ^ v[0]) : v[1]);
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_swupd();
    t_gated();
    t_ungated();
    t_update();
    t_pulse();
    t_refs();
    t_reserved();
    t_latency();
    t_tin1();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule